// File: doc/BRIEF.md
# Compare-Terminated Byte String Loader

This block moves a run of bytes from a byte-wide memory into a bank of 32-bit registers. It packs the bytes big-end first: four bytes fill one register and then the next one. A command names the first address, the first register, a byte budget and a stop byte. The block then fetches one byte at a time. It writes each byte into its lane of the current register and stops as soon as a fetched byte equals the stop byte. When it finishes it reports how many bytes came before the stop byte, or the full budget if no byte matched.

A command also names two base registers. The block never writes those registers. It still steps through their byte lanes, so the following bytes land where they would have landed anyway. The first base register is protected only when its index is nonzero. A register write carries one byte and a one-hot lane enable. The register file merges that single lane and keeps the other three lanes as they were. In narrow mode every address is held to 32 bits, so the address wraps from the top of the 32-bit space back to zero.

The memory read path uses two valid/ready channels. The request channel carries the address. The block holds `rd_req_valid` and `rd_req_addr` steady until `rd_req_ready` is seen at a clock edge. Only one request is ever outstanding. `rd_rsp_ready` is high only while the block waits for the byte of the accepted request. A response is taken on an edge where `rd_rsp_valid` and `rd_rsp_ready` are both high. The command, register-write and completion pins are plain: they have no handshake.

Top module: `cmp_string_loader`

## Requirements
- R1: A command with a byte budget of zero issues no read request. `done` is high in the next cycle, with `result_cnt` = 0.
- R2: Byte k of a run (counting from 0) goes to lane k mod 4. Lane 0 is bits 31:24 and `wr_lane_en` = 4'b1000. Lane 3 is bits 7:0 and `wr_lane_en` = 4'b0001. After lane 3 the run moves on to the next register index.
- R3: The register index wraps from 31 to 0.
- R4: Each register write has exactly one bit of `wr_lane_en` set. `wr_data` is zero outside the enabled lane, so the other lanes of the register keep their contents.
- R5: No write is issued while the current register equals `base_b`, or equals `base_a` with `base_a` nonzero. The lane and register position still advance past that byte.
- R6: When a fetched byte equals `cmp_byte`, that byte is still written (unless R5 blocks it). The run then stops with `result_cnt` equal to the 0-based position of that byte.
- R7: Without a match, exactly `byte_cnt` bytes are requested and `result_cnt` equals `byte_cnt`.
- R8: Request addresses start at `start_addr` and rise by one per byte. In narrow mode (`narrow_mode` = 1 at command time) bits above 31 are forced to zero, including those of the first address.
- R9: `done` is a one-cycle pulse in the cycle after the final response is accepted, and `busy` is low while it is high.
- R10: `rd_req_valid` and `rd_req_addr` hold until accepted. There is at most one outstanding read, and `rd_rsp_ready` is never high together with `rd_req_valid`.
- R11: A `start` pulse while `busy` is high is ignored and does not disturb the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken only while idle |
| start_addr | input | ADDR_W | Address of the first byte |
| start_reg | input | RIDX_W | First destination register |
| byte_cnt | input | CNT_W | Byte budget |
| cmp_byte | input | 8 | Stop byte |
| base_a | input | RIDX_W | Protected register when nonzero |
| base_b | input | RIDX_W | Always-protected register |
| narrow_mode | input | 1 | Keep addresses to 32 bits |
| busy | output | 1 | Run in progress |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block waits for read data |
| rd_rsp_data | input | 8 | Read byte |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | RIDX_W | Register written |
| wr_lane_en | output | 4 | One-hot byte lane enable |
| wr_data | output | 32 | Byte placed in its lane, zero elsewhere |
| done | output | 1 | Completion pulse |
| result_cnt | output | CNT_W | Bytes before the match, or the budget |

## Verification
The bench sweeps start registers near the wrap point, budgets from zero up through several register boundaries, stop bytes placed at the first byte, at the middle and nowhere, and base registers placed in the path of the run. It mirrors the register file from the write port and compares all 32 registers against an arithmetic model. A design that moved the lane the wrong way, failed to wrap, clobbered neighbour lanes or wrote a protected register would show up as a wrong register value. A design that stopped one byte late or early, or counted the matching byte, would report a wrong count or a wrong number of requests. Narrow-mode runs that cross the 32-bit boundary expose a missing truncation, and a start pulse sent mid-run exposes a block that re-arms while busy.

// File: rtl/strld_pkg.sv
package strld_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP
  } strld_state_t;
endpackage

// File: rtl/strld_addr_step.sv
// Adds a small increment to an address and clips it to 32 bits in narrow mode.
module strld_addr_step #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              incr,
  input  logic              narrow,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0] sum;

  assign sum = addr_in + {{(ADDR_W-1){1'b0}}, incr};

  generate
    if (ADDR_W > 32) begin : g_clip
      assign addr_out = narrow ? {{(ADDR_W-32){1'b0}}, sum[31:0]} : sum;
    end else begin : g_pass
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign addr_out = sum;
    end
  endgenerate
endmodule

// File: rtl/strld_lane_pack.sv
// Places a byte into its lane of a register word and makes the lane enable.
module strld_lane_pack
  import strld_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [LANE_W-1:0] lane,
  output logic [WORD_W-1:0] word_out,
  output logic [LANES-1:0]  lane_en
);
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      // lane 0 is the most significant byte
      localparam int HI = WORD_W - 1 - g * BYTE_W;
      logic sel;
      assign sel = (lane == LANE_W'(g));
      assign lane_en[LANES-1-g]        = sel;
      assign word_out[HI -: BYTE_W]    = sel ? byte_in : '0;
    end
  endgenerate
endmodule

// File: rtl/strld_guard.sv
// Flags a destination register that must not be written.
module strld_guard #(
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] cur_idx,
  input  logic [RIDX_W-1:0] base_a,
  input  logic [RIDX_W-1:0] base_b,
  output logic              blocked
);
  logic hit_a, hit_b;

  assign hit_a   = (base_a != '0) && (cur_idx == base_a);
  assign hit_b   = (cur_idx == base_b);
  assign blocked = hit_a | hit_b;
endmodule

// File: rtl/cmp_string_loader.sv
module cmp_string_loader
  import strld_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NUM_REGS = 32,
  parameter int CNT_W    = 7,
  localparam int RIDX_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [RIDX_W-1:0] start_reg,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [7:0]        cmp_byte,
  input  logic [RIDX_W-1:0] base_a,
  input  logic [RIDX_W-1:0] base_b,
  input  logic              narrow_mode,
  output logic              busy,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [7:0]        rd_rsp_data,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [3:0]        wr_lane_en,
  output logic [31:0]       wr_data,
  output logic              done,
  output logic [CNT_W-1:0]  result_cnt
);
  localparam logic [RIDX_W-1:0] LAST_REG  = RIDX_W'(NUM_REGS - 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  strld_state_t      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [RIDX_W-1:0] reg_q;
  logic [LANE_W-1:0] lane_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        cmp_q;
  logic [RIDX_W-1:0] ra_q, rb_q;
  logic              narrow_q;
  logic              done_q;
  logic [CNT_W-1:0]  result_q;

  logic [ADDR_W-1:0] first_addr, next_addr;
  logic              blocked;
  logic              take_cmd, rsp_take, hit, last_byte;
  logic [WORD_W-1:0] packed_word;
  logic [LANES-1:0]  packed_en;

  strld_addr_step #(.ADDR_W(ADDR_W)) u_first (
    .addr_in(start_addr), .incr(1'b0), .narrow(narrow_mode), .addr_out(first_addr)
  );

  strld_addr_step #(.ADDR_W(ADDR_W)) u_next (
    .addr_in(addr_q), .incr(1'b1), .narrow(narrow_q), .addr_out(next_addr)
  );

  strld_guard #(.RIDX_W(RIDX_W)) u_guard (
    .cur_idx(reg_q), .base_a(ra_q), .base_b(rb_q), .blocked(blocked)
  );

  strld_lane_pack u_pack (
    .byte_in(rd_rsp_data), .lane(lane_q), .word_out(packed_word), .lane_en(packed_en)
  );

  assign take_cmd  = (state_q == ST_IDLE) && start;
  assign rsp_take  = (state_q == ST_RSP) && rd_rsp_valid;
  assign hit       = (rd_rsp_data == cmp_q);
  assign last_byte = (CNT_W'(idx_q + 1'b1) == cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      reg_q    <= '0;
      lane_q   <= '0;
      idx_q    <= '0;
      cnt_q    <= '0;
      cmp_q    <= '0;
      ra_q     <= '0;
      rb_q     <= '0;
      narrow_q <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_cmd) begin
            addr_q   <= first_addr;
            reg_q    <= start_reg;
            lane_q   <= '0;
            idx_q    <= '0;
            cnt_q    <= byte_cnt;
            cmp_q    <= cmp_byte;
            ra_q     <= base_a;
            rb_q     <= base_b;
            narrow_q <= narrow_mode;
            if (byte_cnt == '0) begin
              done_q   <= 1'b1;
              result_q <= '0;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (rd_req_ready) state_q <= ST_RSP;
        end
        ST_RSP: begin
          if (rsp_take) begin
            if (hit || last_byte) begin
              state_q  <= ST_IDLE;
              done_q   <= 1'b1;
              result_q <= hit ? idx_q : cnt_q;
            end else begin
              state_q <= ST_REQ;
              idx_q   <= idx_q + 1'b1;
              addr_q  <= next_addr;
              if (lane_q == LAST_LANE) begin
                lane_q <= '0;
                reg_q  <= (reg_q == LAST_REG) ? '0 : reg_q + 1'b1;
              end else begin
                lane_q <= lane_q + 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_req_addr  = addr_q;
  assign rd_rsp_ready = (state_q == ST_RSP);
  assign wr_en        = rsp_take && !blocked;
  assign wr_idx       = reg_q;
  assign wr_lane_en   = packed_en;
  assign wr_data      = packed_word;
  assign done         = done_q;
  assign result_cnt   = result_q;
endmodule

// File: rtl/cmp_string_loader_chk.sv
module cmp_string_loader_chk #(
  parameter int ADDR_W = 64,
  parameter int RIDX_W = 5,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic [RIDX_W-1:0] base_a,
  input logic [RIDX_W-1:0] base_b,
  input logic              narrow_mode,
  input logic              busy,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_ready,
  input logic              wr_en,
  input logic [RIDX_W-1:0] wr_idx,
  input logic [3:0]        wr_lane_en,
  input logic              done,
  input logic [CNT_W-1:0]  result_cnt
);
  logic [RIDX_W-1:0] ra_c, rb_c;
  logic              nar_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ra_c  <= '0;
      rb_c  <= '0;
      nar_c <= 1'b0;
    end else if (start && !busy) begin
      ra_c  <= base_a;
      rb_c  <= base_b;
      nar_c <= narrow_mode;
    end
  end

  assert_zero_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_cnt == '0) |=> (done && result_cnt == '0 && !rd_req_valid));

  assert_single_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_lane_en) == 1));

  assert_skip_protected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_idx != rb_c) && !((ra_c != '0) && (wr_idx == ra_c))));

  generate
    if (ADDR_W > 32) begin : g_wide
      assert_narrow_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && nar_c) |-> (rd_req_addr[ADDR_W-1:32] == '0));
    end
  endgenerate

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));
endmodule

bind cmp_string_loader cmp_string_loader_chk #(
  .ADDR_W(ADDR_W), .RIDX_W(RIDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
  .base_a(base_a), .base_b(base_b), .narrow_mode(narrow_mode), .busy(busy),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .rd_rsp_ready(rd_rsp_ready), .wr_en(wr_en), .wr_idx(wr_idx), .wr_lane_en(wr_lane_en),
  .done(done), .result_cnt(result_cnt)
);

// File: tb/test_cmp_string_loader.sv
`timescale 1ns/1ps
module test_cmp_string_loader;
  localparam int ADDR_W = 64;
  localparam int CNT_W  = 7;
  localparam int RIDX_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [RIDX_W-1:0] start_reg = '0;
  logic [CNT_W-1:0]  byte_cnt = '0;
  logic [7:0]        cmp_byte = '0;
  logic [RIDX_W-1:0] base_a = '0, base_b = '0;
  logic              narrow_mode = 1'b0;
  logic              busy, rd_req_valid, rd_rsp_ready, wr_en, done;
  logic              rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
  logic [7:0]        rd_rsp_data = '0;
  logic [ADDR_W-1:0] rd_req_addr;
  logic [RIDX_W-1:0] wr_idx;
  logic [3:0]        wr_lane_en;
  logic [31:0]       wr_data;
  logic [CNT_W-1:0]  result_cnt;

  always #2 clk = ~clk;

  cmp_string_loader i_cmp_string_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_reg(start_reg), .byte_cnt(byte_cnt), .cmp_byte(cmp_byte),
    .base_a(base_a), .base_b(base_b), .narrow_mode(narrow_mode), .busy(busy),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_lane_en(wr_lane_en), .wr_data(wr_data),
    .done(done), .result_cnt(result_cnt)
  );

  int checks = 0, failures = 0;
  int cyc = 0, last_evt = 0;
  int req_cnt = 0, addr_err = 0, lane_err = 0, lat_err = 0, resp_n = 0;
  logic done_seen = 1'b0;
  logic [CNT_W-1:0] done_res = '0;
  logic [ADDR_W-1:0] exp_addr = '0;
  logic exp_narrow = 1'b0;
  logic [31:0] mirror [32];
  logic [31:0] expect_rf [32];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    return 8'(a[7:0] * 8'd3 + {4'h0, a[35:32]} + 8'h21);
  endfunction

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a, input logic nar);
    logic [ADDR_W-1:0] n;
    n = a + 1;
    if (nar) n[ADDR_W-1:32] = '0;
    return n;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory responder: stalls the request and delays the response by varying amounts
  initial begin
    logic [ADDR_W-1:0] a;
    forever begin
      @(negedge clk);
      if (rd_req_valid) begin
        repeat (resp_n % 3) @(negedge clk);
        a = rd_req_addr;
        if (a != exp_addr) addr_err++;
        exp_addr = step(exp_addr, exp_narrow);
        req_cnt++;
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
        repeat (resp_n % 2) @(negedge clk);
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem_byte(a);
        resp_n++;
        @(negedge clk);
        rd_rsp_valid = 1'b0;
      end
    end
  end

  // monitor: mirrors the register file and times events
  initial begin
    logic [31:0] m;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (start && !busy) last_evt = cyc;
        if (rd_rsp_valid && rd_rsp_ready) last_evt = cyc;
        if (wr_en) begin
          m = {{8{wr_lane_en[3]}}, {8{wr_lane_en[2]}}, {8{wr_lane_en[1]}}, {8{wr_lane_en[0]}}};
          if ($countones(wr_lane_en) != 1 || (wr_data & ~m) != 0) lane_err++;
          mirror[wr_idx] = (mirror[wr_idx] & ~m) | (wr_data & m);
        end
        if (done) begin
          if (cyc != last_evt + 1) lat_err++;
          done_seen = 1'b1;
          done_res  = result_cnt;
        end
      end
    end
  end

  task automatic run_op(input logic [ADDR_W-1:0] sa, input int sreg, input int cnt,
                        input logic [7:0] cmpv, input int ra, input int rb,
                        input logic nar, input logic poke);
    logic [ADDR_W-1:0] a;
    int r, lane, res, nreq, bad;
    logic [7:0] b;
    for (int i = 0; i < 32; i++) begin
      mirror[i]    = 32'h5A000000 ^ (i * 32'h01030507);
      expect_rf[i] = mirror[i];
    end
    a = nar ? {32'h0, sa[31:0]} : sa;
    r = sreg; lane = 0; res = cnt; nreq = 0;
    for (int i = 0; i < cnt; i++) begin
      b = mem_byte(a);
      nreq++;
      if (!(r == rb || (ra != 0 && r == ra)))
        expect_rf[r][31 - 8*lane -: 8] = b;
      if (b == cmpv) begin res = i; break; end
      a = step(a, nar);
      if (lane == 3) begin lane = 0; r = (r + 1) % 32; end
      else lane++;
    end
    @(negedge clk);
    exp_addr = nar ? {32'h0, sa[31:0]} : sa;
    exp_narrow = nar;
    req_cnt = 0; addr_err = 0; lane_err = 0; lat_err = 0; done_seen = 1'b0;
    start = 1'b1; start_addr = sa; start_reg = RIDX_W'(sreg); byte_cnt = CNT_W'(cnt);
    cmp_byte = cmpv; base_a = RIDX_W'(ra); base_b = RIDX_W'(rb); narrow_mode = nar;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R11: a second command mid-run with different settings must be ignored
      @(negedge clk);
      start = 1'b1; start_addr = ~sa; start_reg = RIDX_W'(sreg + 9); byte_cnt = '0;
      cmp_byte = ~cmpv; base_a = RIDX_W'(sreg); base_b = RIDX_W'(sreg + 1);
      @(negedge clk);
      start = 1'b0;
    end
    while (!done_seen) @(posedge clk);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 32; i++) if (mirror[i] !== expect_rf[i]) bad++;
    check(bad == 0, "R2 R3 R5", "registers differing", bad, 0);
    check(done_res == CNT_W'(res), (res < cnt) ? "R6" : "R7", "result", done_res, res);
    check(req_cnt == nreq, (cnt == 0) ? "R1" : "R7", "requests", req_cnt, nreq);
    check(addr_err == 0, "R8", "address errors", addr_err, 0);
    check(lane_err == 0, "R4", "lane errors", lane_err, 0);
    check(lat_err == 0, "R9", "done latency errors", lat_err, 0);
    if (poke) check(done_res == CNT_W'(res), "R11", "result after busy start", done_res, res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_req_valid && !wr_en && !rd_rsp_ready, "R9",
          "reset state", {busy, done, rd_req_valid, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 32; s += 7) begin
      for (int c = 0; c <= 10; c++) begin
        for (int m = 0; m < 3; m++) begin
          logic [ADDR_W-1:0] sa;
          logic [7:0] cv;
          int ra, rb;
          sa = 64'h0000_0003_0000_0040 + 64'(s * 16 + c);
          cv = (m == 0) ? mem_byte(sa + 200) : (m == 1) ? mem_byte(sa) : mem_byte(sa + 64'(c / 2));
          ra = (m == 2) ? s : 0;
          rb = (m == 0) ? (s + 1) % 32 : (m == 1) ? 31 : (s + 2) % 32;
          run_op(sa, s, c, cv, ra, rb, 1'b0, 1'b0);
        end
      end
    end
    // R3: wrap from register 31 to 0, protected base_a nonzero in the path
    run_op(64'h100, 30, 14, 8'h00, 1, 3, 1'b0, 1'b0);
    run_op(64'h200, 31, 9, mem_byte(64'h207), 0, 0, 1'b0, 1'b0);
    // R8: narrow mode crosses the 32-bit boundary; wide mode does not truncate
    run_op(64'hABCD_0000_FFFF_FFFD, 4, 7, 8'h00, 0, 20, 1'b1, 1'b0);
    run_op(64'h0000_0000_FFFF_FFFE, 4, 6, 8'h00, 0, 20, 1'b0, 1'b0);
    // R11: start pulses while busy
    run_op(64'h300, 8, 10, mem_byte(64'h308), 0, 9, 1'b0, 1'b1);
    run_op(64'h400, 12, 5, mem_byte(64'h500), 13, 2, 1'b0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule